// File: doc/BRIEF.md
# Receiver Sampling-Phase Sweep Controller

This block searches for the best sampling phase, or input delay tap, for a serial stream that crosses a board trace from a transmitter fed by the same reference clock. A start request makes it step a tap setting upward from zero across a configurable range. It presents each tap with a one-cycle apply strobe. It then judges the tap from two status inputs of a descrambling receiver: a level that is high while the descrambler has no lock, and a bit-error pulse that the receiver also holds high while lock is missing.

Each tap is judged in three timed stages. The settle stage gives a bad link time to show lost lock, and ends early once it does. The lock-wait stage gives the receiver a bounded time to regain lock. The dwell stage requires a clean error input for its whole length. Stage lengths are given in bit times and converted to parallel-word clock cycles. When the last tap has been judged, the block applies the centre tap of the longest unbroken run of good taps and raises done. If no tap was good, it also raises fail and parks the tap at the middle of the range.

Top module: `phase_sweep_ctrl`

## Requirements
- R1: After reset, tap_o, chosen_o, apply_o, done_o and fail_o are all zero.
- R2: start_i is accepted only while idle or done. Acceptance clears done_o and fail_o and begins a sweep at tap 0. start_i pulses during a sweep have no effect. tap_o changes only in a cycle where apply_o is high, and apply_o is never high for two cycles in a row.
- R3: A sweep applies taps 0, 1, ... NUM_TAPS-1 in ascending order, each exactly once, followed by exactly one further apply carrying the chosen tap.
- R4: Settle stage. If sync_lost_i stays low for SETTLE cycles after the apply cycle, the dwell stage starts. A clean tap therefore reaches its next apply SETTLE+DWELL+2 cycles after its own apply.
- R5: Lock-wait stage. If sync_lost_i is high during the settle stage, lock-wait starts in the next cycle. The tap moves to dwell in the cycle after sync_lost_i is seen low. If sync_lost_i stays high for LOCK cycles of lock-wait, the tap is bad and the next apply follows LOCK+3 cycles after the tap's apply.
- R6: Dwell stage. A tap is good only if bit_error_i and sync_lost_i stay low for all DWELL cycles. The first error ends the dwell at once and marks the tap bad.
- R7: SETTLE, LOCK and DWELL equal the corresponding bit-time parameter divided by WORD_W, rounded up.
- R8: The chosen tap is S + (N-1)/2, rounded down, where S is the start and N the length of the longest run of consecutive good taps. Between runs of equal length, the lowest-numbered run wins.
- R9: After the last tap, one extra cycle passes. The chosen tap is then applied with an apply pulse, and done_o rises in the following cycle. While done_o is high, tap_o equals chosen_o, with no apply pulses, until the next accepted start.
- R10: If no tap is good, fail_o rises together with done_o, and the tap is NUM_TAPS/2.
- R11: While a sweep is running, no more than SETTLE+LOCK+DWELL+3 cycles pass between two apply pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-word clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sweep (accepted when idle or done) |
| sync_lost_i | input | 1 | Receiver descrambler not locked |
| bit_error_i | input | 1 | Receiver bit-error pulse, held high without lock |
| tap_o | output | TAP_W | Tap setting for the phase or delay hardware |
| apply_o | output | 1 | One-cycle strobe when tap_o takes a new value |
| done_o | output | 1 | Sweep finished, chosen tap in effect |
| fail_o | output | 1 | Sweep finished with no good tap |
| chosen_o | output | TAP_W | Tap picked by the last sweep |

## Verification
The assertions check on every cycle the properties that hold throughout a run. These are the reset values, the single-cycle apply strobe, and tap changes only under the strobe. They also cover the upper bound on the time spent at one tap, and the agreement of tap, chosen tap, done and fail once a sweep ends. Only the bench scenarios show the rest: the exact stage timing of each path (early settle exit, late lock, lock timeout, error mid-dwell), the ascending tap order, and the longest-run centre with its tie rule. They also show a run that reaches the top tap, the all-bad fallback, and that a start pulse in mid-sweep changes nothing.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [3:0] {
    PS_IDLE,
    PS_APPLY,
    PS_SETTLE,
    PS_LOCK,
    PS_DWELL,
    PS_NEXT,
    PS_PICK,
    PS_SHOW,
    PS_DONE
  } psw_state_e;

  function automatic int unsigned bits_to_cycles(input int unsigned bits,
                                                 input int unsigned word_w);
    return (bits + word_w - 1) / word_w;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psw_timer.sv
module psw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q != limit_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign expired_o = (cnt_q == limit_i);

endmodule

// File: rtl/psw_run_tracker.sv
module psw_run_tracker #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             good_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] best_start_o,
  output logic [LEN_W-1:0] best_len_o
);

  logic [IDX_W-1:0] cur_start_q, best_start_q;
  logic [LEN_W-1:0] cur_len_q, best_len_q;
  logic [IDX_W-1:0] run_start_n;
  logic [LEN_W-1:0] run_len_n;

  always_comb begin
    run_start_n = (cur_len_q == '0) ? idx_i : cur_start_q;
    run_len_n   = cur_len_q + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (upd_i) begin
      if (good_i) begin
        cur_start_q <= run_start_n;
        cur_len_q   <= run_len_n;
        // strict compare: an equal-length later run does not displace the earlier one
        if (run_len_n > best_len_q) begin
          best_start_q <= run_start_n;
          best_len_q   <= run_len_n;
        end
      end else begin
        cur_len_q <= '0;
      end
    end
  end

  assign best_start_o = best_start_q;
  assign best_len_o   = best_len_q;

endmodule

// File: rtl/psw_centre.sv
module psw_centre #(
  parameter int NUM_TAPS = 32,
  parameter int IDX_W    = 5,
  parameter int LEN_W    = 6
) (
  input  logic [IDX_W-1:0] best_start_i,
  input  logic [LEN_W-1:0] best_len_i,
  output logic [IDX_W-1:0] tap_o,
  output logic             none_o
);

  localparam int SUM_W = (LEN_W > IDX_W) ? LEN_W + 1 : IDX_W + 1;
  localparam logic [IDX_W-1:0] MID_TAP = IDX_W'(NUM_TAPS / 2);

  logic [LEN_W-1:0] half_len;
  logic [SUM_W-1:0] sum;

  always_comb begin
    none_o   = (best_len_i == '0);
    half_len = (best_len_i - LEN_W'(1)) >> 1;
    sum      = SUM_W'(best_start_i) + SUM_W'(half_len);
    tap_o    = none_o ? MID_TAP : sum[IDX_W-1:0];
  end

endmodule

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl
  import psw_pkg::*;
#(
  parameter int unsigned NUM_TAPS    = 32,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned SETTLE_BITS = 32'd4194560,
  parameter int unsigned LOCK_BITS   = 32'd33554432,
  parameter int unsigned DWELL_BITS  = 32'd33554432,
  localparam int TAP_W = (NUM_TAPS > 2) ? $clog2(NUM_TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sync_lost_i,
  input  logic             bit_error_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             apply_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [TAP_W-1:0] chosen_o
);

  localparam int unsigned SETTLE_CYC = bits_to_cycles(SETTLE_BITS, WORD_W);
  localparam int unsigned LOCK_CYC   = bits_to_cycles(LOCK_BITS, WORD_W);
  localparam int unsigned DWELL_CYC  = bits_to_cycles(DWELL_BITS, WORD_W);
  localparam int unsigned MAX_CYC    = max3(SETTLE_CYC, LOCK_CYC, DWELL_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int LEN_W = $clog2(NUM_TAPS + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  psw_state_e state_q, state_d;
  logic [TAP_W-1:0] tap_q, chosen_q;
  logic             apply_q, done_q, fail_q, verdict_q;
  logic [CNT_W-1:0] limit;
  logic             expired;
  logic             accept, busy_w, link_err;
  logic [TAP_W-1:0] best_start, centre_tap;
  logic [LEN_W-1:0] best_len;
  logic             none_good;

  assign accept   = start_i && ((state_q == PS_IDLE) || (state_q == PS_DONE));
  assign busy_w   = (state_q != PS_IDLE) && (state_q != PS_DONE);
  assign link_err = bit_error_i || sync_lost_i;

  always_comb begin
    unique case (state_q)
      PS_SETTLE: limit = CNT_W'(SETTLE_CYC - 1);
      PS_LOCK:   limit = CNT_W'(LOCK_CYC - 1);
      default:   limit = CNT_W'(DWELL_CYC - 1);
    endcase
  end

  psw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (state_d != state_q),
    .limit_i   (limit),
    .expired_o (expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE, PS_DONE: if (start_i) state_d = PS_APPLY;
      PS_APPLY:         state_d = PS_SETTLE;
      PS_SETTLE: begin
        if (sync_lost_i)  state_d = PS_LOCK;
        else if (expired) state_d = PS_DWELL;
      end
      PS_LOCK: begin
        if (!sync_lost_i) state_d = PS_DWELL;
        else if (expired) state_d = PS_NEXT;
      end
      PS_DWELL: begin
        if (link_err || expired) state_d = PS_NEXT;
      end
      PS_NEXT:  state_d = (tap_q == LAST_TAP) ? PS_PICK : PS_APPLY;
      PS_PICK:  state_d = PS_SHOW;
      PS_SHOW:  state_d = PS_DONE;
      default:  state_d = PS_IDLE;
    endcase
  end

  psw_run_tracker #(.IDX_W(TAP_W), .LEN_W(LEN_W)) u_runs (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (accept),
    .upd_i        (state_q == PS_NEXT),
    .good_i       (verdict_q),
    .idx_i        (tap_q),
    .best_start_o (best_start),
    .best_len_o   (best_len)
  );

  psw_centre #(.NUM_TAPS(NUM_TAPS), .IDX_W(TAP_W), .LEN_W(LEN_W)) u_centre (
    .best_start_i (best_start),
    .best_len_i   (best_len),
    .tap_o        (centre_tap),
    .none_o       (none_good)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PS_IDLE;
      tap_q     <= '0;
      chosen_q  <= '0;
      apply_q   <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      verdict_q <= 1'b0;
    end else begin
      state_q <= state_d;
      apply_q <= (state_d == PS_APPLY) || (state_d == PS_SHOW);
      done_q  <= (state_d == PS_DONE);
      fail_q  <= (state_d == PS_DONE) && none_good;

      if (accept) begin
        tap_q <= '0;
      end else if (state_q == PS_NEXT && state_d == PS_APPLY) begin
        tap_q <= tap_q + TAP_W'(1);
      end else if (state_q == PS_PICK) begin
        tap_q    <= centre_tap;
        chosen_q <= centre_tap;
      end

      if (state_q == PS_APPLY) begin
        verdict_q <= 1'b0;
      end else if (state_q == PS_DWELL && !link_err && expired) begin
        verdict_q <= 1'b1;
      end
    end
  end

  assign tap_o    = tap_q;
  assign apply_o  = apply_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign chosen_o = chosen_q;

endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
  parameter int unsigned NUM_TAPS = 32,
  parameter int TAP_W = 5,
  parameter int unsigned BOUND = 100
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_i,
  input logic             apply_i,
  input logic             done_i,
  input logic             fail_i,
  input logic [TAP_W-1:0] tap_i,
  input logic [TAP_W-1:0] chosen_i
);

  int unsigned since_apply;

  always_ff @(posedge clk) begin
    if (rst || apply_i) since_apply <= 0;
    else if (since_apply <= BOUND) since_apply <= since_apply + 1;
  end

  // R1
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!apply_i && !done_i && !fail_i && tap_i == '0 && chosen_i == '0));

  // R2
  p_apply_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    apply_i |=> !apply_i);

  // R2
  p_tap_under_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(tap_i) |-> apply_i);

  // R11
  p_tap_time_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !apply_i) |-> (since_apply <= BOUND));

  // R9
  p_done_tap_r9: assert property (@(posedge clk) disable iff (rst)
    done_i |-> (tap_i == chosen_i && !apply_i));

  // R10
  p_fail_mid_r10: assert property (@(posedge clk) disable iff (rst)
    fail_i |-> (done_i && chosen_i == TAP_W'(NUM_TAPS / 2)));

endmodule

bind phase_sweep_ctrl psw_checker #(
  .NUM_TAPS (NUM_TAPS),
  .TAP_W    (TAP_W),
  .BOUND    (SETTLE_CYC + LOCK_CYC + DWELL_CYC + 3)
) u_psw_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_i   (busy_w),
  .apply_i  (apply_o),
  .done_i   (done_o),
  .fail_i   (fail_o),
  .tap_i    (tap_o),
  .chosen_i (chosen_o)
);

// File: tb/phase_sweep_ctrl_tb_top.sv
module phase_sweep_ctrl_tb_top;

  localparam int NT = 8;
  localparam int TW = 3;
  localparam int WW = 4;
  localparam int SB = 16;   // 4 cycles
  localparam int LB = 32;   // 8 cycles
  localparam int DB = 30;   // rounds up to 8 cycles
  localparam int S  = (SB + WW - 1) / WW;
  localparam int L  = (LB + WW - 1) / WW;
  localparam int D  = (DB + WW - 1) / WW;
  localparam int KG = 5;      // late lock that succeeds
  localparam int KB = 30;     // lock never arrives in window
  localparam int EP = S + 2;  // error pulse inside dwell

  logic clk = 1'b0;
  logic rst, start_i, sync_lost_i, bit_error_i;
  logic [TW-1:0] tap_o, chosen_o;
  logic apply_o, done_o, fail_o;

  always #5 clk = ~clk;

  phase_sweep_ctrl #(
    .NUM_TAPS(NT), .WORD_W(WW), .SETTLE_BITS(SB), .LOCK_BITS(LB), .DWELL_BITS(DB)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sync_lost_i(sync_lost_i),
    .bit_error_i(bit_error_i), .tap_o(tap_o), .apply_o(apply_o),
    .done_o(done_o), .fail_o(fail_o), .chosen_o(chosen_o)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int since = 0;
  int mode_q[NT];
  int n_app = 0;
  int app_tap[16];
  int app_cyc[16];
  bit rec = 1'b0;
  bit finished = 1'b0;

  // link modes: 0 clean, 1 never locks, 2 locks late, 3 error in dwell, 5 locks too late
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (apply_o) begin
      since = 0;
      if (rec && n_app < 16) begin
        app_tap[n_app] = int'(tap_o);
        app_cyc[n_app] = cyc;
        n_app++;
      end
    end else begin
      since++;
    end
    case (mode_q[tap_o])
      0: begin sync_lost_i = 1'b0; bit_error_i = 1'b0; end
      1: begin sync_lost_i = 1'b1; bit_error_i = 1'b1; end
      2: begin sync_lost_i = (since < KG); bit_error_i = (since < KG); end
      3: begin sync_lost_i = 1'b0; bit_error_i = (since == EP); end
      default: begin sync_lost_i = (since < KB); bit_error_i = (since < KB); end
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ivl(input int md);
    case (md)
      0:       return S + D + 2;
      2:       return KG + 2 + D;
      3:       return EP + 2;
      default: return L + 3;
    endcase
  endfunction

  function automatic string ivl_req(input int md);
    case (md)
      0:       return "R4 R7 clean tap timing";
      2:       return "R5 late lock timing";
      3:       return "R6 dwell error timing";
      default: return "R5 lock timeout timing";
    endcase
  endfunction

  task automatic run_scn(input int m[NT], input bit mid_start);
    int best_s, best_n, cur_s, cur_n, exp_tap, w;
    bit exp_fail;
    mode_q = m;
    best_s = 0; best_n = 0; cur_s = 0; cur_n = 0;
    for (int i = 0; i < NT; i++) begin
      if (m[i] == 0 || m[i] == 2) begin
        if (cur_n == 0) cur_s = i;
        cur_n++;
        if (cur_n > best_n) begin best_n = cur_n; best_s = cur_s; end
      end else begin
        cur_n = 0;
      end
    end
    exp_fail = (best_n == 0);
    exp_tap  = exp_fail ? NT / 2 : best_s + (best_n - 1) / 2;

    n_app = 0;
    rec = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(!done_o && !fail_o, "R2 start clears done", int'(done_o), 0);
    if (mid_start) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 5000) begin
      @(negedge clk);
      w++;
    end
    rec = 1'b0;
    chk(done_o, "R9 done raised", int'(done_o), 1);
    chk(n_app == NT + 1, mid_start ? "R2 mid-sweep start ignored" : "R3 apply count",
        n_app, NT + 1);
    for (int i = 0; i < NT && i < n_app; i++)
      chk(app_tap[i] == i, "R3 ascending tap order", app_tap[i], i);
    for (int i = 0; i < NT && i + 1 < n_app; i++)
      chk(app_cyc[i+1] - app_cyc[i] == ivl(m[i]) + ((i == NT - 1) ? 1 : 0),
          ivl_req(m[i]), app_cyc[i+1] - app_cyc[i], ivl(m[i]) + ((i == NT - 1) ? 1 : 0));
    if (n_app == NT + 1)
      chk(app_tap[NT] == exp_tap, "R8 centre of longest run applied", app_tap[NT], exp_tap);
    chk(int'(chosen_o) == exp_tap, "R8 chosen tap", int'(chosen_o), exp_tap);
    chk(fail_o == exp_fail, "R10 fail flag", int'(fail_o), int'(exp_fail));
    repeat (5) @(negedge clk);
    chk(done_o && !apply_o && int'(tap_o) == exp_tap, "R9 done holds tap",
        int'(tap_o), exp_tap);
  endtask

  initial begin
    int sc[NT];
    rst = 1'b1; start_i = 1'b0;
    for (int i = 0; i < NT; i++) mode_q[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tap_o == '0 && chosen_o == '0 && !apply_o && !done_o && !fail_o,
        "R1 reset state", int'(tap_o), 0);

    sc = '{1, 0, 0, 1, 0, 0, 0, 1}; run_scn(sc, 1'b1);  // longest later run
    sc = '{0, 0, 3, 0, 0, 5, 3, 1}; run_scn(sc, 1'b0);  // tie keeps earlier run
    sc = '{1, 3, 5, 1, 1, 3, 1, 5}; run_scn(sc, 1'b0);  // nothing good
    sc = '{0, 2, 0, 2, 0, 0, 2, 0}; run_scn(sc, 1'b0);  // all good
    sc = '{2, 2, 2, 2, 3, 0, 0, 0}; run_scn(sc, 1'b0);  // run at the low end
    sc = '{1, 1, 1, 1, 1, 0, 0, 0}; run_scn(sc, 1'b0);  // run reaches top tap
    sc = '{1, 1, 1, 0, 1, 1, 1, 1}; run_scn(sc, 1'b0);  // single good tap

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule